// File: doc/BRIEF.md
# Speculative Load-Store Ordering Checker

This block sits beside a reorder buffer and rules on two questions each cycle: may the load that is asking for memory go now, and may a store write memory now. It holds one slot per reorder-buffer entry. A slot becomes an active store when the issue stage allocates a store into that entry. It learns the store's effective address later, when the address unit reports it by tag. The slot is released when the entry commits at the head or when the buffer is flushed.

A load presents its own reorder-buffer tag and word address. Every active store that is older than the load is compared against it. Age is the distance from the head pointer, taken modulo the depth. The load is held if any older store has the same address, or if any older store has not reported its address yet. The requester keeps asking until the grant appears. Only the store sitting at the head, with a known address, is offered to memory. This keeps memory updates in program order. Parameters set the depth, the address width and how many low address bits the comparison ignores, so that partial overlaps within a coarser unit count as conflicts.

Top module: `lso_order_check`

## Requirements
- R1: After reset no slot holds a store: `st_wr_en` is 0 and a load request of any tag and address is granted.
- R2: When the slot at `head_ptr` holds an active store whose address is known, `st_wr_en` is 1 in that same cycle and `st_wr_addr` carries that store's address.
- R3: `st_wr_en` is 0 whenever the head slot holds no active store or holds a store with an unknown address. Stores in other slots never drive a write, and an address update aimed at a slot that holds no store is ignored.
- R4: A load is denied while an older active store has an address equal to the load's address once the low `MATCH_LSB` bits are ignored (the bench uses `MATCH_LSB` = 1, so addresses 4 and 5 conflict).
- R5: A load is denied while any older active store has not yet reported its address.
- R6: A slot is older than the load when `(slot - head_ptr) mod DEPTH` is smaller than `(ld_tag - head_ptr) mod DEPTH`. Stores that are not older, including one in the load's own slot, never block it, so a load whose tag equals `head_ptr` is always granted.
- R7: A `commit_vld` pulse releases the slot at `head_ptr` at the clock edge. A load held only by that store is granted in the following cycle and not in the commit cycle.
- R8: A `flush` pulse releases every slot at the clock edge, taking priority over an allocation or an update in the same cycle. A held load is granted in the next cycle.
- R9: Allocation and address updates take effect at the clock edge. An update in the same cycle as a load request does not change that cycle's grant.
- R10: An older store with a known, non-matching address does not block the load.
- R11: `ld_grant` is 0 whenever `ld_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_st_vld | input | 1 | A store is allocated into the slot named by `alloc_st_tag` |
| alloc_st_tag | input | TW | Reorder-buffer tag of the allocated store |
| addr_upd_vld | input | 1 | Effective address of a store is reported |
| addr_upd_tag | input | TW | Tag of the store whose address is reported |
| addr_upd_val | input | AW | Reported word address |
| head_ptr | input | TW | Current reorder-buffer head |
| commit_vld | input | 1 | The head entry retires at this edge |
| flush | input | 1 | Discard all speculative entries |
| ld_req | input | 1 | A load asks to access memory |
| ld_tag | input | TW | Reorder-buffer tag of the load |
| ld_addr | input | AW | Word address of the load |
| ld_grant | output | 1 | The load may access memory this cycle |
| st_wr_en | output | 1 | The head store may write memory this cycle |
| st_wr_addr | output | AW | Address of the head store |

## Verification
Two functions can meet in one cycle: a load asks while the store that holds it is committing, is being flushed, or is receiving its address. The bench provokes each case directly. It drives the commit, flush or address update in the same cycle as a pending load request. It judges the grant once before the clock edge, where it must still be denied, and once after the edge, where the new state rules. An exhaustive sweep over head position, store slot, load slot, address state and both addresses on a four-entry buffer compares each grant and write enable with the ring-age formula worked out in the bench.

// File: rtl/lso_pkg.sv
package lso_pkg;

   // distance of a ring slot from the head, modulo the ring depth
   function automatic int unsigned ring_age(input int unsigned idx,
                                            input int unsigned head,
                                            input int unsigned depth);
      return (idx + depth - head) % depth;
   endfunction

   typedef enum logic [1:0] {
      HZ_NONE    = 2'd0,
      HZ_UNKNOWN = 2'd1,
      HZ_MATCH   = 2'd2
   } hazard_e;

endpackage

// File: rtl/lso_slot.sv
module lso_slot #(
   parameter int AW        = 32,
   parameter int MATCH_LSB = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_hit,
   input  logic          upd_hit,
   input  logic [AW-1:0] upd_addr,
   input  logic          retire,
   input  logic          flush,
   input  logic [AW-1:0] probe_addr,
   output logic          busy,
   output logic          known,
   output logic [AW-1:0] addr,
   output logic          match
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         known <= 1'b0;
         addr  <= '0;
      end else if (flush || retire) begin
         busy  <= 1'b0;
         known <= 1'b0;
      end else begin
         if (alloc_hit) begin
            busy  <= 1'b1;
            known <= 1'b0;
         end
         if (upd_hit && (busy || alloc_hit)) begin
            known <= 1'b1;
            addr  <= upd_addr;
         end
      end
   end

   generate
      if (MATCH_LSB == 0) begin : g_exact
         assign match = (addr == probe_addr);
      end else begin : g_coarse
         assign match = (addr[AW-1:MATCH_LSB] == probe_addr[AW-1:MATCH_LSB]);
      end
   endgenerate

endmodule

// File: rtl/lso_hazard.sv
module lso_hazard
   import lso_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic             ld_req,
   input  logic [DEPTH-1:0] busy,
   input  logic [DEPTH-1:0] known,
   input  logic [DEPTH-1:0] match,
   input  logic [DEPTH-1:0] older,
   output hazard_e          cause,
   output logic             grant
);

   logic [DEPTH-1:0] wait_unknown;
   logic [DEPTH-1:0] wait_match;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         wait_unknown[i] = busy[i] & older[i] & ~known[i];
         wait_match[i]   = busy[i] & older[i] &  known[i] & match[i];
      end
   end

   always_comb begin
      if (|wait_unknown)    cause = HZ_UNKNOWN;
      else if (|wait_match) cause = HZ_MATCH;
      else                  cause = HZ_NONE;
   end

   assign grant = ld_req && (cause == HZ_NONE);

endmodule

// File: rtl/lso_head_port.sv
module lso_head_port #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   localparam int TW   = $clog2(DEPTH)
) (
   input  logic [TW-1:0]             head_ptr,
   input  logic [DEPTH-1:0]          busy,
   input  logic [DEPTH-1:0]          known,
   input  logic [DEPTH-1:0][AW-1:0]  addr,
   output logic                      wr_en,
   output logic [AW-1:0]             wr_addr
);

   assign wr_en   = busy[head_ptr] & known[head_ptr];
   assign wr_addr = addr[head_ptr];

endmodule

// File: rtl/lso_order_check.sv
module lso_order_check
   import lso_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int AW        = 32,
   parameter int MATCH_LSB = 0,
   localparam int TW       = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_st_vld,
   input  logic [TW-1:0] alloc_st_tag,
   input  logic          addr_upd_vld,
   input  logic [TW-1:0] addr_upd_tag,
   input  logic [AW-1:0] addr_upd_val,
   input  logic [TW-1:0] head_ptr,
   input  logic          commit_vld,
   input  logic          flush,
   input  logic          ld_req,
   input  logic [TW-1:0] ld_tag,
   input  logic [AW-1:0] ld_addr,
   output logic          ld_grant,
   output logic          st_wr_en,
   output logic [AW-1:0] st_wr_addr
);

   initial begin
      if (DEPTH < 2 || (1 << TW) != DEPTH)
         $fatal(1, "lso_order_check: DEPTH must be a power of two, at least 2");
      if (MATCH_LSB < 0 || MATCH_LSB >= AW)
         $fatal(1, "lso_order_check: MATCH_LSB must lie inside the address");
   end

   logic [DEPTH-1:0]         slot_busy;
   logic [DEPTH-1:0]         slot_known;
   logic [DEPTH-1:0]         slot_match;
   logic [DEPTH-1:0]         slot_older;
   logic [DEPTH-1:0][AW-1:0] slot_addr;
   hazard_e                  ld_cause;

   int unsigned load_age;
   assign load_age = ring_age(int'(ld_tag), int'(head_ptr), DEPTH);

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic alloc_hit;
         logic upd_hit;
         logic retire;

         assign alloc_hit = alloc_st_vld && (alloc_st_tag == TW'(g));
         assign upd_hit   = addr_upd_vld && (addr_upd_tag == TW'(g));
         assign retire    = commit_vld   && (head_ptr     == TW'(g));
         assign slot_older[g] = ring_age(g, int'(head_ptr), DEPTH) < load_age;

         lso_slot #(
            .AW        (AW),
            .MATCH_LSB (MATCH_LSB)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_hit  (alloc_hit),
            .upd_hit    (upd_hit),
            .upd_addr   (addr_upd_val),
            .retire     (retire),
            .flush      (flush),
            .probe_addr (ld_addr),
            .busy       (slot_busy[g]),
            .known      (slot_known[g]),
            .addr       (slot_addr[g]),
            .match      (slot_match[g])
         );
      end
   endgenerate

   lso_hazard #(
      .DEPTH (DEPTH)
   ) u_hazard (
      .ld_req (ld_req),
      .busy   (slot_busy),
      .known  (slot_known),
      .match  (slot_match),
      .older  (slot_older),
      .cause  (ld_cause),
      .grant  (ld_grant)
   );

   lso_head_port #(
      .DEPTH (DEPTH),
      .AW    (AW)
   ) u_head (
      .head_ptr (head_ptr),
      .busy     (slot_busy),
      .known    (slot_known),
      .addr     (slot_addr),
      .wr_en    (st_wr_en),
      .wr_addr  (st_wr_addr)
   );

endmodule

// File: rtl/lso_order_check_chk.sv
module lso_order_check_chk #(
   parameter int DEPTH = 16,
   parameter int AW    = 32,
   localparam int TW   = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             addr_upd_vld,
   input logic [TW-1:0]    addr_upd_tag,
   input logic [TW-1:0]    head_ptr,
   input logic             commit_vld,
   input logic             flush,
   input logic             ld_req,
   input logic [TW-1:0]    ld_tag,
   input logic             ld_grant,
   input logic             st_wr_en,
   input logic [DEPTH-1:0] slot_busy,
   input logic [DEPTH-1:0] slot_known
);

   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_req |-> !ld_grant); // R11

   AST_OLDEST_LOAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && ld_tag == head_ptr) |-> ld_grant); // R6

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (slot_busy == '0)); // R8

   AST_COMMIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_vld && st_wr_en) |=> !slot_busy[$past(head_ptr)]); // R7

   AST_UPDATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_upd_vld && !flush && slot_busy[addr_upd_tag] &&
       !(commit_vld && head_ptr == addr_upd_tag))
      |=> slot_known[$past(addr_upd_tag)]); // R9

   AST_WRITE_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr_en |-> (slot_busy != '0)); // R3

endmodule

bind lso_order_check lso_order_check_chk #(
   .DEPTH (DEPTH),
   .AW    (AW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr_upd_vld (addr_upd_vld),
   .addr_upd_tag (addr_upd_tag),
   .head_ptr     (head_ptr),
   .commit_vld   (commit_vld),
   .flush        (flush),
   .ld_req       (ld_req),
   .ld_tag       (ld_tag),
   .ld_grant     (ld_grant),
   .st_wr_en     (st_wr_en),
   .slot_busy    (slot_busy),
   .slot_known   (slot_known)
);

// File: tb/lso_order_check_tb.sv
module lso_order_check_tb;

   localparam int DEPTH = 4;
   localparam int AW    = 4;
   localparam int MLSB  = 1;
   localparam int TW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_st_vld = 1'b0;
   logic [TW-1:0] alloc_st_tag = '0;
   logic          addr_upd_vld = 1'b0;
   logic [TW-1:0] addr_upd_tag = '0;
   logic [AW-1:0] addr_upd_val = '0;
   logic [TW-1:0] head_ptr = '0;
   logic          commit_vld = 1'b0;
   logic          flush = 1'b0;
   logic          ld_req = 1'b0;
   logic [TW-1:0] ld_tag = '0;
   logic [AW-1:0] ld_addr = '0;
   logic          ld_grant;
   logic          st_wr_en;
   logic [AW-1:0] st_wr_addr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   lso_order_check #(.DEPTH(DEPTH), .AW(AW), .MATCH_LSB(MLSB)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_st_vld(alloc_st_vld), .alloc_st_tag(alloc_st_tag),
      .addr_upd_vld(addr_upd_vld), .addr_upd_tag(addr_upd_tag),
      .addr_upd_val(addr_upd_val), .head_ptr(head_ptr),
      .commit_vld(commit_vld), .flush(flush),
      .ld_req(ld_req), .ld_tag(ld_tag), .ld_addr(ld_addr),
      .ld_grant(ld_grant), .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic quiet();
      alloc_st_vld = 1'b0;
      addr_upd_vld = 1'b0;
      commit_vld   = 1'b0;
      flush        = 1'b0;
   endtask

   function automatic int age(input int x, input int h);
      return (x - h) & (DEPTH - 1);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: empty after reset
      #2;
      check("R11 no request no grant", int'(ld_grant), 0);
      check("R1 no write after reset", int'(st_wr_en), 0);
      ld_req = 1'b1; ld_tag = 2'd3; ld_addr = 4'd9; #1;
      check("R1 load granted after reset", int'(ld_grant), 1);

      // exhaustive sweep: R2 R3 R4 R5 R6 R10
      for (int h = 0; h < DEPTH; h++)
         for (int st = 0; st < DEPTH; st++)
            for (int lt = 0; lt < DEPTH; lt++)
               for (int kn = 0; kn < 2; kn++)
                  for (int sa = 0; sa < (kn ? 16 : 1); sa++)
                     for (int la = 0; la < 16; la++) begin
                        bit older, blk, wexp;
                        tick(); quiet(); ld_req = 1'b0; flush = 1'b1;
                        tick(); quiet(); alloc_st_vld = 1'b1; alloc_st_tag = TW'(st);
                        tick(); quiet();
                        if (kn != 0) begin
                           addr_upd_vld = 1'b1; addr_upd_tag = TW'(st);
                           addr_upd_val = AW'(sa);
                        end
                        tick(); quiet();
                        head_ptr = TW'(h); ld_req = 1'b1;
                        ld_tag = TW'(lt); ld_addr = AW'(la);
                        #2;
                        older = age(st, h) < age(lt, h);
                        blk   = older && (kn == 0 || (sa >> MLSB) == (la >> MLSB));
                        wexp  = (st == h) && (kn != 0);
                        if (kn == 0 && older)
                           check("R5 unknown older store", int'(ld_grant), 0);
                        else if (!older)
                           check("R6 younger store ignored", int'(ld_grant), 1);
                        else if (blk)
                           check("R4 address conflict", int'(ld_grant), 0);
                        else
                           check("R10 distinct address", int'(ld_grant), 1);
                        if (wexp) begin
                           check("R2 head store write", int'(st_wr_en), 1);
                           check("R2 head store address", int'(st_wr_addr), sa);
                        end else begin
                           check("R3 no write off head", int'(st_wr_en), 0);
                        end
                     end

      // R7: commit in the same cycle as a held load
      tick(); quiet(); ld_req = 1'b0; flush = 1'b1;
      tick(); quiet(); alloc_st_vld = 1'b1; alloc_st_tag = 2'd0;
      tick(); quiet(); addr_upd_vld = 1'b1; addr_upd_tag = 2'd0; addr_upd_val = 4'd6;
      tick(); quiet(); head_ptr = 2'd0; ld_req = 1'b1; ld_tag = 2'd2; ld_addr = 4'd7;
      commit_vld = 1'b1; #2;
      check("R7 held during commit cycle", int'(ld_grant), 0);
      check("R2 write offered in commit cycle", int'(st_wr_en), 1);
      tick(); quiet(); head_ptr = 2'd1; #2;
      check("R7 granted after commit", int'(ld_grant), 1);
      head_ptr = 2'd0; #1;
      check("R7 released slot gives no write", int'(st_wr_en), 0);

      // R8: flush in the same cycle as a held load
      tick(); quiet(); ld_req = 1'b0; alloc_st_vld = 1'b1; alloc_st_tag = 2'd1;
      tick(); quiet(); alloc_st_vld = 1'b1; alloc_st_tag = 2'd2;
      tick(); quiet(); head_ptr = 2'd1; ld_req = 1'b1; ld_tag = 2'd3; ld_addr = 4'd0;
      flush = 1'b1; #2;
      check("R8 held during flush cycle", int'(ld_grant), 0);
      tick(); quiet(); #2;
      check("R8 granted after flush", int'(ld_grant), 1);

      // R8: flush wins over allocation in the same cycle
      tick(); quiet(); ld_req = 1'b0; flush = 1'b1; alloc_st_vld = 1'b1; alloc_st_tag = 2'd1;
      tick(); quiet(); head_ptr = 2'd1; ld_req = 1'b1; ld_tag = 2'd2; #2;
      check("R8 flush beats allocation", int'(ld_grant), 1);

      // R9: address update in the same cycle as the load
      tick(); quiet(); ld_req = 1'b0; flush = 1'b1;
      tick(); quiet(); alloc_st_vld = 1'b1; alloc_st_tag = 2'd0;
      tick(); quiet(); head_ptr = 2'd0; ld_req = 1'b1; ld_tag = 2'd1; ld_addr = 4'd8;
      addr_upd_vld = 1'b1; addr_upd_tag = 2'd0; addr_upd_val = 4'd2; #2;
      check("R9 update not seen same cycle", int'(ld_grant), 0);
      tick(); quiet(); #2;
      check("R9 update seen next cycle", int'(ld_grant), 1);

      // R5 then R10 with two older stores
      tick(); quiet(); ld_req = 1'b0; flush = 1'b1;
      tick(); quiet(); alloc_st_vld = 1'b1; alloc_st_tag = 2'd1;
      tick(); quiet(); alloc_st_vld = 1'b1; alloc_st_tag = 2'd2;
      addr_upd_vld = 1'b1; addr_upd_tag = 2'd1; addr_upd_val = 4'd4;
      tick(); quiet(); head_ptr = 2'd1; ld_req = 1'b1; ld_tag = 2'd3; ld_addr = 4'd10; #2;
      check("R5 one older address unknown", int'(ld_grant), 0);
      tick(); quiet(); addr_upd_vld = 1'b1; addr_upd_tag = 2'd2; addr_upd_val = 4'd12;
      tick(); quiet(); #2;
      check("R10 both older addresses distinct", int'(ld_grant), 1);
      ld_addr = 4'd5; #1;
      check("R4 partial overlap conflicts", int'(ld_grant), 0);

      // R3: update to a slot holding no store is ignored
      tick(); quiet(); addr_upd_vld = 1'b1; addr_upd_tag = 2'd3; addr_upd_val = 4'd0;
      tick(); quiet(); head_ptr = 2'd3; ld_req = 1'b0; #2;
      check("R3 stray update ignored", int'(st_wr_en), 0);
      check("R11 no request no grant", int'(ld_grant), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule